// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block is the configuration front end of a legacy-style peripheral cluster on a byte-wide I/O bus. Two adjacent I/O addresses are decoded: an index port at 0x4E, which picks a register, and a data port at 0x4F, which reads or writes the picked register. After reset the register file is sealed. A host opens it by writing the key bytes 0x80 and then 0x86 to the index port, and seals it again by writing 0x68 and then 0x08 to the same port.

While the file is open, index 0x07 holds a device selector. Three devices with selector values 0x04, 0x05 and 0x06 (two serial ports and a watchdog) each own a bank with an activate bit and a 16-bit I/O base. The bank that the selector names is the one reached through the data port. One shared register at index 0x29 is reachable whatever the selector holds. It carries an interrupt enable and a two-bit clock predivide code, and its bit 1 is read-only.

The bus is a plain single-cycle strobe interface with no back-pressure. A write takes effect on the clock edge where `io_wr` is high. `io_rdata` is combinational from the current address and register state. Reads have no side effects, so no read strobe exists. The per-device enables and bases and the shared fields leave the block as plain level outputs.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the block is sealed, `dev_en`, `dev_base`, `irq_en` and `clk_prediv` are all zero, and `io_rdata` at the data port reads 0xFF.
- R2: Writing 0x80 and then 0x86 to the index port (0x4E) opens the block. A further 0x80 in place of 0x86 keeps the tracker waiting for 0x86.
- R3: While sealed, any other byte written to the index port before the opening sequence is complete sends the tracker back to its start. For example, 0x80, 0x11, 0x86 leaves the block sealed.
- R4: While sealed, data port writes change nothing and data port reads return 0xFF.
- R5: Writing 0x68 and then 0x08 to the index port seals the block. Any other index byte after 0x68 leaves the block open, and that byte becomes the index.
- R6: Index 0x07 is the device selector. It is written and read back as a full byte through the data port.
- R7: Index 0x30 bit 0 is the activate bit of the selected device, and it drives `dev_en[k]` for selector value 0x04+k. It reads back as {7'b0, bit}.
- R8: Indices 0x60 and 0x61 are the high and low bytes of the selected device's base, which appears on `dev_base[16k+15:16k]`.
- R9: Index 0x29 is shared regardless of the selector. Bit 0 drives `irq_en` and bits [3:2] drive `clk_prediv` (0 = divide by 1, 1 = by 8, 2 = by 26, 3 = reserved but stored).
- R10: Bit 1 of index 0x29 ignores writes and reads 0. Bits [7:4] of index 0x29 also read 0.
- R11: Unimplemented indices read 0x00. With a selector value outside 0x04..0x06, writes to 0x30, 0x60 and 0x61 change no device, and reads of those indices return 0x00.
- R12: Writes to any address other than 0x4E and 0x4F affect neither the lock state nor any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for the addressed port (0xFF unless data port is open) |
| dev_en | output | 3 | Activate bit per device, bit k for selector 0x04+k |
| dev_base | output | 48 | I/O base per device, 16 bits each, device k at [16k+15:16k] |
| irq_en | output | 1 | Shared interrupt enable |
| clk_prediv | output | 2 | Shared clock predivide code |

## Verification
The bench goes after broken key sequences: a stray byte between 0x80 and 0x86, a repeated 0x80, and an exit sequence cut short by another index. A tracker that ignores the stray byte would open the block too early. One that does not restart would never open it. One that seals on 0x68 alone would lock the host out mid-session. It also writes through a selector that names no bank and writes all-ones into the shared register. A faulty decode there would corrupt a real device, or bit 1 would read back as 1. Random mixes of key bytes, indices and data at the two ports and at nearby addresses are compared against a bench model after every write.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  typedef enum logic [1:0] {
    ST_SEALED = 2'd0,
    ST_KEY1   = 2'd1,
    ST_OPEN   = 2'd2,
    ST_EXIT1  = 2'd3
  } lock_st_t;

  localparam logic [7:0] KEY_OPEN_A  = 8'h80;
  localparam logic [7:0] KEY_OPEN_B  = 8'h86;
  localparam logic [7:0] KEY_SEAL_A  = 8'h68;
  localparam logic [7:0] KEY_SEAL_B  = 8'h08;

  localparam logic [7:0] IX_SELECT   = 8'h07;
  localparam logic [7:0] IX_SHARED   = 8'h29;
  localparam logic [7:0] IX_ACTIVATE = 8'h30;
  localparam logic [7:0] IX_BASE_HI  = 8'h60;
  localparam logic [7:0] IX_BASE_LO  = 8'h61;
endpackage

// File: rtl/sio_lock_fsm.sv
module sio_lock_fsm
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       unlocked
);
  lock_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (idx_wr) begin
      unique case (st_q)
        ST_SEALED: if (wdata == KEY_OPEN_A) st_d = ST_KEY1;
        ST_KEY1: begin
          if (wdata == KEY_OPEN_B)      st_d = ST_OPEN;
          else if (wdata == KEY_OPEN_A) st_d = ST_KEY1;
          else                          st_d = ST_SEALED;
        end
        ST_OPEN: if (wdata == KEY_SEAL_A) st_d = ST_EXIT1;
        ST_EXIT1: begin
          if (wdata == KEY_SEAL_B)      st_d = ST_SEALED;
          else if (wdata == KEY_SEAL_A) st_d = ST_EXIT1;
          else                          st_d = ST_OPEN;
        end
        default: st_d = ST_SEALED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_SEALED;
    else        st_q <= st_d;
  end

  assign unlocked = (st_q == ST_OPEN) || (st_q == ST_EXIT1);

  AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && !$past(unlocked)) |-> ($past(idx_wr) && $past(wdata) == KEY_OPEN_B)); // R2
  AST_SEAL_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && $past(unlocked)) |-> ($past(idx_wr) && $past(wdata) == KEY_SEAL_B)); // R5
  AST_STRAY_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_KEY1 && idx_wr && wdata != KEY_OPEN_A && wdata != KEY_OPEN_B)
      |=> (st_q == ST_SEALED)); // R3
endmodule

// File: rtl/sio_dev_bank.sv
module sio_dev_bank (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_act,
  input  logic        wr_hi,
  input  logic        wr_lo,
  input  logic [7:0]  wdata,
  output logic        en,
  output logic [15:0] base
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= 1'b0;
      base <= 16'h0000;
    end else begin
      if (wr_act) en <= wdata[0];
      if (wr_hi)  base[15:8] <= wdata;
      if (wr_lo)  base[7:0]  <= wdata;
    end
  end

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_act || wr_hi || wr_lo) |=> ($stable(en) && $stable(base))); // R11
  AST_ACT_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_act |=> (en == $past(wdata[0]))); // R7
  AST_BASE_HI: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (base[15:8] == $past(wdata))); // R8
endmodule

// File: rtl/sio_shared_reg.sv
module sio_shared_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [2:0] wbits,
  output logic       irq_en,
  output logic [1:0] prediv,
  output logic [7:0] rd_val
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en <= 1'b0;
      prediv <= 2'b00;
    end else if (wr) begin
      irq_en <= wbits[0];
      prediv <= wbits[2:1];
    end
  end

  assign rd_val = {4'b0000, prediv, 1'b0, irq_en};

  AST_SHARED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (irq_en == $past(wbits[0]) && prediv == $past(wbits[2:1]))); // R9
  AST_SHARED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(irq_en) && $stable(prediv))); // R4
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned BASE_ADDR = 16'h004E,
  parameter int unsigned NUM_DEV   = 3,
  parameter int unsigned SEL_FIRST = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     io_addr,
  input  logic                  io_wr,
  input  logic [7:0]            io_wdata,
  output logic [7:0]            io_rdata,
  output logic [NUM_DEV-1:0]    dev_en,
  output logic [NUM_DEV*16-1:0] dev_base,
  output logic                  irq_en,
  output logic [1:0]            clk_prediv
);
  localparam logic [ADDR_W-1:0] IDX_PORT = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] DAT_PORT = ADDR_W'(BASE_ADDR + 1);

  logic        unlocked;
  logic        idx_wr, dat_wr;
  logic [7:0]  idx_q, sel_q;
  logic [7:0]  shared_rd;
  logic [7:0]  reg_rd;
  logic [NUM_DEV-1:0] hit;
  logic [NUM_DEV-1:0] en_v;
  logic [15:0] base_v [NUM_DEV];

  assign idx_wr = io_wr && (io_addr == IDX_PORT);
  assign dat_wr = io_wr && (io_addr == DAT_PORT) && unlocked;

  sio_lock_fsm u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_wr   (idx_wr),
    .wdata    (io_wdata),
    .unlocked (unlocked)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        idx_q <= 8'h00;
    else if (!unlocked) idx_q <= 8'h00;
    else if (idx_wr)   idx_q <= io_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                sel_q <= 8'h00;
    else if (dat_wr && idx_q == IX_SELECT)     sel_q <= io_wdata;
  end

  sio_shared_reg u_shared (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (dat_wr && idx_q == IX_SHARED),
    .wbits  ({io_wdata[3:2], io_wdata[0]}),
    .irq_en (irq_en),
    .prediv (clk_prediv),
    .rd_val (shared_rd)
  );

  for (genvar k = 0; k < NUM_DEV; k++) begin : g_dev
    localparam logic [7:0] MY_SEL = 8'(SEL_FIRST + k);
    assign hit[k] = (sel_q == MY_SEL);

    sio_dev_bank u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_act (dat_wr && hit[k] && idx_q == IX_ACTIVATE),
      .wr_hi  (dat_wr && hit[k] && idx_q == IX_BASE_HI),
      .wr_lo  (dat_wr && hit[k] && idx_q == IX_BASE_LO),
      .wdata  (io_wdata),
      .en     (en_v[k]),
      .base   (base_v[k])
    );

    assign dev_en[k]             = en_v[k];
    assign dev_base[16*k +: 16]  = base_v[k];
  end

  always_comb begin
    reg_rd = 8'h00;
    unique case (idx_q)
      IX_SELECT: reg_rd = sel_q;
      IX_SHARED: reg_rd = shared_rd;
      IX_ACTIVATE, IX_BASE_HI, IX_BASE_LO: begin
        for (int k = 0; k < NUM_DEV; k++) begin
          if (hit[k]) begin
            if (idx_q == IX_ACTIVATE)     reg_rd = {7'b0, en_v[k]};
            else if (idx_q == IX_BASE_HI) reg_rd = base_v[k][15:8];
            else                          reg_rd = base_v[k][7:0];
          end
        end
      end
      default: reg_rd = 8'h00;
    endcase
  end

  assign io_rdata = (io_addr == DAT_PORT && unlocked) ? reg_rd : 8'hFF;

  AST_SEALED_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> (io_rdata == 8'hFF)); // R4
  AST_SEALED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && io_wr) |=> ($stable(dev_en) && $stable(dev_base) && $stable(sel_q))); // R4
  AST_FOREIGN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr != IDX_PORT && io_addr != DAT_PORT)
      |=> ($stable(unlocked) && $stable(idx_q) && $stable(dev_en) && $stable(irq_en))); // R12
  AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit)); // R7
endmodule

// File: tb/sio_cfg_port_test.sv
module sio_cfg_port_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] PI = 16'h004E;
  localparam logic [15:0] PD = 16'h004F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic        io_wr = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic [2:0]  dev_en;
  logic [47:0] dev_base;
  logic        irq_en;
  logic [1:0]  clk_prediv;

  int total = 0;
  int bad = 0;

  // bench model
  logic        m_en [3];
  logic [15:0] m_base [3];
  logic        m_irq;
  logic [1:0]  m_pre;
  logic [7:0]  m_sel;
  logic [7:0]  m_idx;
  int          m_st; // 0 sealed, 1 got first open key, 2 open, 3 got first seal key

  sio_cfg_port uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .dev_en(dev_en),
    .dev_base(dev_base), .irq_en(irq_en), .clk_prediv(clk_prediv)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog: run did not finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic int dev_of(input logic [7:0] s);
    if (s >= 8'h04 && s <= 8'h06) return int'(s) - 4;
    return -1;
  endfunction

  function automatic logic [7:0] exp_read();
    int d;
    d = dev_of(m_sel);
    if (m_st < 2) return 8'hFF;
    case (m_idx)
      8'h07: return m_sel;
      8'h29: return {4'b0, m_pre, 1'b0, m_irq};
      8'h30: return (d >= 0) ? {7'b0, m_en[d]} : 8'h00;
      8'h60: return (d >= 0) ? m_base[d][15:8] : 8'h00;
      8'h61: return (d >= 0) ? m_base[d][7:0] : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_wr(input logic [15:0] a, input logic [7:0] v);
    int d;
    if (a == PI) begin
      if (m_st >= 2) m_idx = v;
      case (m_st)
        0: if (v == 8'h80) m_st = 1;
        1: m_st = (v == 8'h86) ? 2 : (v == 8'h80) ? 1 : 0;
        2: if (v == 8'h68) m_st = 3;
        default: m_st = (v == 8'h08) ? 0 : (v == 8'h68) ? 3 : 2;
      endcase
      if (m_st < 2) m_idx = 8'h00;
    end else if (a == PD && m_st >= 2) begin
      d = dev_of(m_sel);
      case (m_idx)
        8'h07: m_sel = v;
        8'h29: begin m_irq = v[0]; m_pre = v[3:2]; end
        8'h30: if (d >= 0) m_en[d] = v[0];
        8'h60: if (d >= 0) m_base[d][15:8] = v;
        8'h61: if (d >= 0) m_base[d][7:0] = v;
        default: ;
      endcase
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] v);
    @(negedge clk);
    io_addr = a; io_wdata = v; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    model_wr(a, v);
  endtask

  task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [2:0]  e_en;
    logic [47:0] e_base;
    for (int k = 0; k < 3; k++) begin
      e_en[k] = m_en[k];
      e_base[16*k +: 16] = m_base[k];
    end
    io_addr = PD; io_wr = 1'b0;
    #1;
    check_eq({tag, " rdata"}, 64'(io_rdata), 64'(exp_read()));
    check_eq({tag, " dev_en"}, 64'(dev_en), 64'(e_en));
    check_eq({tag, " dev_base"}, 64'(dev_base), 64'(e_base));
    check_eq({tag, " irq_en"}, 64'(irq_en), 64'(m_irq));
    check_eq({tag, " clk_prediv"}, 64'(clk_prediv), 64'(m_pre));
  endtask

  task automatic wreg(input logic [7:0] ix, input logic [7:0] v);
    bus_wr(PI, ix);
    bus_wr(PD, v);
  endtask

  initial begin
    logic [7:0] keys [10];
    void'($urandom(32'h5EED_0042));
    keys = '{8'h80, 8'h86, 8'h68, 8'h08, 8'h07, 8'h30, 8'h60, 8'h61, 8'h29, 8'h04};
    for (int k = 0; k < 3; k++) begin m_en[k] = 1'b0; m_base[k] = 16'h0; end
    m_irq = 1'b0; m_pre = 2'b00; m_sel = 8'h00; m_idx = 8'h00; m_st = 0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset state");
    check_eq("R1 sealed read", 64'(io_rdata), 64'hFF);

    // R4: writes while sealed ignored
    bus_wr(PD, 8'hFF);
    bus_wr(PI, 8'h30); bus_wr(PD, 8'hFF);
    check_all("R4 sealed write");

    // R3: stray byte restarts the tracker
    bus_wr(PI, 8'h80); bus_wr(PI, 8'h11); bus_wr(PI, 8'h86);
    check_all("R3 stray key byte");
    check_eq("R3 still sealed", 64'(io_rdata), 64'hFF);

    // R2: repeated first key, then second key opens
    bus_wr(PI, 8'h80); bus_wr(PI, 8'h80); bus_wr(PI, 8'h86);
    bus_wr(PI, 8'h07);
    check_all("R2 opened");
    check_eq("R2 selector reads 00", 64'(io_rdata), 64'h00);

    // R6: selector
    bus_wr(PD, 8'h04);
    check_all("R6 selector 04");
    check_eq("R6 selector readback", 64'(io_rdata), 64'h04);

    // R7, R8: device banks
    wreg(8'h30, 8'hFF);
    check_all("R7 activate dev0");
    check_eq("R7 activate readback", 64'(io_rdata), 64'h01);
    wreg(8'h60, 8'h03); wreg(8'h61, 8'hF8);
    check_all("R8 base dev0");
    check_eq("R8 base low readback", 64'(io_rdata), 64'hF8);
    wreg(8'h07, 8'h05); wreg(8'h60, 8'h02); wreg(8'h61, 8'hF8); wreg(8'h30, 8'h01);
    check_all("R8 base dev1");
    wreg(8'h07, 8'h06); wreg(8'h30, 8'h01); wreg(8'h60, 8'h0C);
    check_all("R7 activate dev2");

    // R11: selector without a bank, unimplemented index
    wreg(8'h07, 8'h09); wreg(8'h30, 8'h00); wreg(8'h60, 8'hAA);
    check_all("R11 no bank");
    check_eq("R11 no bank readback", 64'(io_rdata), 64'h00);
    wreg(8'h55, 8'h77);
    check_all("R11 unimplemented index");

    // R9, R10: shared register
    wreg(8'h29, 8'hFF);
    check_all("R9 shared all ones");
    check_eq("R10 read-only bit", 64'(io_rdata), 64'h0D);
    wreg(8'h29, 8'h0A);
    check_all("R9 shared predivide 26");
    check_eq("R10 readback 08", 64'(io_rdata), 64'h08);

    // R12: foreign addresses
    bus_wr(16'h004D, 8'h68); bus_wr(16'h0050, 8'h08);
    bus_wr(16'h014E, 8'h68); bus_wr(16'h014E, 8'h08);
    check_all("R12 foreign addresses");

    // R5: interrupted exit stays open, full exit seals
    bus_wr(PI, 8'h68); bus_wr(PI, 8'h07);
    check_all("R5 interrupted exit");
    check_eq("R5 still open", 64'(io_rdata), 64'h09);
    bus_wr(PI, 8'h68); bus_wr(PI, 8'h08);
    check_all("R5 sealed again");
    bus_wr(PD, 8'h55);
    check_all("R4 sealed after exit");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int r;
      logic [15:0] a;
      logic [7:0]  v;
      r = int'($urandom_range(0, 99));
      if (r < 45) begin
        a = PI;
        v = ($urandom_range(0, 3) == 0) ? 8'($urandom) : keys[$urandom_range(0, 9)];
      end else if (r < 92) begin
        a = PD;
        v = ($urandom_range(0, 2) == 0) ? keys[$urandom_range(0, 9)] : 8'($urandom);
      end else begin
        a = ($urandom_range(0, 1) == 0) ? 16'h004D : 16'h0050;
        v = keys[$urandom_range(0, 9)];
      end
      bus_wr(a, v);
      check_all("random R2 R3 R5 R6 R7 R8 R9 R12");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule